// File: doc/BRIEF.md
# Block I/O Request Queue and Dispatcher

This block sits between a set of clients that issue block read and write requests and a single downstream command sequencer that drives the disk. Each request carries a client tag, a logical block address, a drive select and a direction bit. Requests are held strictly in the order they were accepted. Only the request at the head of the queue is ever presented to the sequencer.

Dispatch is triggered in one of two ways. A request that lands in an empty queue is launched at once. Otherwise the sequencer's completion pulse for the head request launches its successor. On completion the head is retired. The owning client is woken through a one-hot completion vector indexed by tag, and the sequencer's error status is passed along with it. A completion pulse that arrives when nothing is outstanding is dropped and tallied in a spurious-event counter.

Top module: `disk_req_dispatch`

## Requirements
- R1: After reset, `req_ready` is 1, `disp_valid`, `disp_issue` and `done_mask` are 0, and `spur_cnt` is 0.
- R2: Requests are dispatched in exactly the order they were accepted. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1.
- R3: A request accepted while no request is outstanding makes `disp_issue` high for one cycle, starting on the next cycle. In that cycle `disp_tag`, `disp_lba`, `disp_drive` and `disp_write` equal the accepted request, where `disp_write`=1 means a write.
- R4: At most one request is outstanding. `disp_valid` is 1 exactly while one is outstanding. The dispatch fields hold steady until that request completes, and `disp_issue` pulses only when a new head is launched.
- R5: A `cmpl_irq` pulse while a request is outstanding retires it. On the next cycle, `done_mask` has exactly the bit at index `disp_tag` set and `done_err` equals the sampled `cmpl_err`, for one cycle. Otherwise `done_mask` and `done_err` are 0.
- R6: If another request is queued when the head retires, it is launched in the same cycle as the completion output: `disp_issue`=1 with the new head's fields. Otherwise `disp_valid` drops to 0.
- R7: `req_ready` is 0 while DEPTH (default 8) requests are held. A `req_valid` presented then is not enqueued.
- R8: A `cmpl_irq` pulse with no request outstanding produces no completion output. It increments `spur_cnt` by one, and the counter wraps modulo 2^CNT_W.
- R9: If the last held request retires on the same edge that a new request is accepted, the new request is launched on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Queue can accept a request |
| req_tag | input | 3 | Client tag of the request |
| req_lba | input | 28 | Logical block address |
| req_drive | input | 1 | Drive select |
| req_write | input | 1 | 1 = write, 0 = read |
| disp_valid | output | 1 | A request is outstanding at the sequencer |
| disp_issue | output | 1 | One-cycle launch strobe for the current head |
| disp_tag | output | 3 | Tag of the outstanding request |
| disp_lba | output | 28 | Address of the outstanding request |
| disp_drive | output | 1 | Drive of the outstanding request |
| disp_write | output | 1 | Direction of the outstanding request |
| cmpl_irq | input | 1 | Completion pulse from the sequencer |
| cmpl_err | input | ERR_W | Error status accompanying the completion |
| done_mask | output | 8 | One-hot per-tag completion strobe |
| done_err | output | ERR_W | Error status for the completed tag |
| spur_cnt | output | CNT_W | Count of completions with nothing outstanding |

## Verification
The bench targets four corner cases. The first is an arrival into an empty queue on the same edge as a stray completion. A design that treated this completion as real would retire the new request before it ever launched. The second is the retirement of the last entry on the same edge as a new acceptance. A design that checked only the old count would leave the new request stranded and never issued. The bench also fills the queue and keeps pushing, which catches an off-by-one full flag that would overwrite the head. It drives bursts of completions against an empty queue, where a wrong design would emit phantom done strobes or miscount.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int DQ_NUM_TAGS = 8;
    localparam int DQ_TAG_W    = $clog2(DQ_NUM_TAGS);
    localparam int DQ_LBA_W    = 28;

    typedef struct packed {
        logic [DQ_TAG_W-1:0] tag;
        logic [DQ_LBA_W-1:0] lba;
        logic                drive;
        logic                write;
    } dq_req_t;
endpackage

// File: rtl/dq_fifo.sv
module dq_fifo
    import dq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  dq_req_t          wdata,
    output dq_req_t          head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    dq_req_t    slots_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = bump(st_q.wr);
        if (pop)  st_d.rd = bump(st_q.rd);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) slots_q[st_q.wr] <= wdata;
    end

    assign head  = slots_q[st_q.rd];
    assign count = st_q.cnt;
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/dq_ctrl.sv
module dq_ctrl
    import dq_pkg::*;
#(
    parameter int QCNT_W = 4,
    parameter int ERR_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   cmpl_irq,
    input  logic [ERR_W-1:0]       cmpl_err,
    input  logic                   q_full,
    input  logic                   q_empty,
    input  logic [QCNT_W-1:0]      q_count,
    input  logic [DQ_TAG_W-1:0]    head_tag,
    output logic                   push,
    output logic                   pop,
    output logic                   issue,
    output logic [DQ_NUM_TAGS-1:0] done_mask,
    output logic [ERR_W-1:0]       done_err,
    output logic [CNT_W-1:0]       spur_cnt
);
    typedef struct packed {
        logic                   issue;
        logic [DQ_NUM_TAGS-1:0] done;
        logic [ERR_W-1:0]       err;
        logic [CNT_W-1:0]       spur;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        successor;

    always_comb begin
        push      = req_valid && !q_full;
        pop       = cmpl_irq && !q_empty;
        successor = (q_count > QCNT_W'(1)) || push;

        st_d       = st_q;
        st_d.issue = 1'b0;
        st_d.done  = '0;
        st_d.err   = '0;
        if (pop) begin
            st_d.done = DQ_NUM_TAGS'(1) << head_tag;
            st_d.err  = cmpl_err;
            st_d.issue = successor;
        end else if (cmpl_irq) begin
            st_d.spur = st_q.spur + 1'b1;
        end
        if (q_empty && push) st_d.issue = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign issue     = st_q.issue;
    assign done_mask = st_q.done;
    assign done_err  = st_q.err;
    assign spur_cnt  = st_q.spur;
endmodule

// File: rtl/disk_req_dispatch.sv
module disk_req_dispatch
    import dq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ERR_W = 8,
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [DQ_TAG_W-1:0]    req_tag,
    input  logic [DQ_LBA_W-1:0]    req_lba,
    input  logic                   req_drive,
    input  logic                   req_write,
    output logic                   disp_valid,
    output logic                   disp_issue,
    output logic [DQ_TAG_W-1:0]    disp_tag,
    output logic [DQ_LBA_W-1:0]    disp_lba,
    output logic                   disp_drive,
    output logic                   disp_write,
    input  logic                   cmpl_irq,
    input  logic [ERR_W-1:0]       cmpl_err,
    output logic [DQ_NUM_TAGS-1:0] done_mask,
    output logic [ERR_W-1:0]       done_err,
    output logic [CNT_W-1:0]       spur_cnt
);
    localparam int QCNT_W = $clog2(DEPTH + 1);

    dq_req_t           in_req, head;
    logic              push, pop, q_full, q_empty;
    logic [QCNT_W-1:0] q_count;

    assign in_req = '{tag: req_tag, lba: req_lba, drive: req_drive, write: req_write};

    dq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (in_req),
        .head  (head),
        .count (q_count),
        .empty (q_empty),
        .full  (q_full)
    );

    dq_ctrl #(.QCNT_W(QCNT_W), .ERR_W(ERR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .cmpl_irq  (cmpl_irq),
        .cmpl_err  (cmpl_err),
        .q_full    (q_full),
        .q_empty   (q_empty),
        .q_count   (q_count),
        .head_tag  (head.tag),
        .push      (push),
        .pop       (pop),
        .issue     (disp_issue),
        .done_mask (done_mask),
        .done_err  (done_err),
        .spur_cnt  (spur_cnt)
    );

    assign req_ready  = !q_full;
    assign disp_valid = !q_empty;
    assign disp_tag   = head.tag;
    assign disp_lba   = head.lba;
    assign disp_drive = head.drive;
    assign disp_write = head.write;
endmodule

// File: rtl/dq_chk.sv
module dq_chk
    import dq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_ready,
    input logic                   disp_valid,
    input logic                   disp_issue,
    input logic [DQ_TAG_W-1:0]    disp_tag,
    input logic [DQ_LBA_W-1:0]    disp_lba,
    input logic                   cmpl_irq,
    input logic [DQ_NUM_TAGS-1:0] done_mask,
    input logic [CNT_W-1:0]       spur_cnt
);
    // R4
    issue_needs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_issue |-> disp_valid);

    // R4
    head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !cmpl_irq) |=> ($stable(disp_tag) && $stable(disp_lba) && disp_valid));

    // R5
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_mask));

    // R5
    done_follows_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_irq && disp_valid) |=> (done_mask != '0));

    // R8
    spurious_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_irq && !disp_valid) |=> (done_mask == '0 && spur_cnt == CNT_W'($past(spur_cnt) + 1'b1)));

    // R7
    full_means_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> disp_valid);
endmodule

bind disk_req_dispatch dq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .disp_valid (disp_valid),
    .disp_issue (disp_issue),
    .disp_tag   (disp_tag),
    .disp_lba   (disp_lba),
    .cmpl_irq   (cmpl_irq),
    .done_mask  (done_mask),
    .spur_cnt   (spur_cnt)
);

// File: tb/tb_disk_req_dispatch.sv
`timescale 1ns/1ps
module tb_disk_req_dispatch;
    import dq_pkg::*;
    localparam int DEPTH = 8;
    localparam int ERR_W = 8;
    localparam int CNT_W = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic                   req_ready;
    logic [DQ_TAG_W-1:0]    req_tag = '0;
    logic [DQ_LBA_W-1:0]    req_lba = '0;
    logic                   req_drive = 1'b0;
    logic                   req_write = 1'b0;
    logic                   disp_valid, disp_issue, disp_drive, disp_write;
    logic [DQ_TAG_W-1:0]    disp_tag;
    logic [DQ_LBA_W-1:0]    disp_lba;
    logic                   cmpl_irq = 1'b0;
    logic [ERR_W-1:0]       cmpl_err = '0;
    logic [DQ_NUM_TAGS-1:0] done_mask;
    logic [ERR_W-1:0]       done_err;
    logic [CNT_W-1:0]       spur_cnt;

    always #2 clk = ~clk;

    disk_req_dispatch #(.DEPTH(DEPTH), .ERR_W(ERR_W), .CNT_W(CNT_W)) dut (.*);

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_en   = 1'b0;
    bit finished = 1'b0;

    // behavioural reference
    dq_req_t m_q[$];
    int      m_issue, m_done, m_err, m_spur;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_issue = 0; m_done = 0; m_err = 0; m_spur = 0;
        end else begin
            automatic bit was_empty = (m_q.size() == 0);
            automatic bit acc = req_valid && (m_q.size() < DEPTH);
            automatic dq_req_t nr;
            nr.tag = req_tag; nr.lba = req_lba; nr.drive = req_drive; nr.write = req_write;
            m_issue = 0; m_done = 0; m_err = 0;
            if (cmpl_irq && !was_empty) begin
                m_done = 1 << m_q[0].tag;
                m_err  = cmpl_err;
                void'(m_q.pop_front());
            end else if (cmpl_irq) begin
                m_spur = (m_spur + 1) % (1 << CNT_W);
            end
            if (acc) m_q.push_back(nr);
            if (was_empty && acc) m_issue = 1;
            if (!was_empty && cmpl_irq && m_q.size() > 0) m_issue = 1;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n && !finished) begin
            automatic bit mv = (m_q.size() > 0);
            chk(req_ready == (m_q.size() < DEPTH), "R7", "req_ready", req_ready, m_q.size() < DEPTH);
            chk(disp_valid == mv, "R4", "disp_valid", disp_valid, mv);
            chk(disp_issue == m_issue[0], "R3/R6", "disp_issue", disp_issue, m_issue);
            if (mv) begin
                chk(disp_tag == m_q[0].tag && disp_lba == m_q[0].lba &&
                    disp_drive == m_q[0].drive && disp_write == m_q[0].write,
                    "R2", "head fields", {disp_tag, disp_lba, disp_drive, disp_write}, m_q[0]);
            end
            chk(done_mask == DQ_NUM_TAGS'(m_done), "R5", "done_mask", done_mask, m_done);
            chk(done_err == ERR_W'(m_err), "R5", "done_err", done_err, m_err);
            chk(spur_cnt == CNT_W'(m_spur), "R8", "spur_cnt", spur_cnt, m_spur);
        end
    end

    task automatic idle();
        req_valid = 1'b0; cmpl_irq = 1'b0;
    endtask

    task automatic put(input int tag, input int lba, input bit drv, input bit wr);
        req_valid = 1'b1; req_tag = DQ_TAG_W'(tag); req_lba = DQ_LBA_W'(lba);
        req_drive = drv; req_write = wr;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(req_ready == 1'b1 && disp_valid == 1'b0 && disp_issue == 1'b0, "R1", "ctl after reset",
            {req_ready, disp_valid, disp_issue}, 3'b100);
        chk(done_mask == '0 && spur_cnt == '0, "R1", "status after reset", {done_mask, spur_cnt}, 0);
        cmp_en = 1'b1;

        // R3: single read into empty queue, then completion with error
        put(5, 'h123456, 1'b0, 1'b0); step(1); idle(); step(3);
        cmpl_irq = 1'b1; cmpl_err = 8'h41; step(1); idle(); step(2);

        // R2 / R6: three back-to-back, completed one by one
        put(1, 'h10, 1'b1, 1'b1); step(1);
        put(2, 'h20, 1'b0, 1'b0); step(1);
        put(3, 'h30, 1'b1, 1'b0); step(1); idle(); step(2);
        for (int i = 0; i < 3; i++) begin
            cmpl_irq = 1'b1; cmpl_err = ERR_W'(i); step(1); idle(); step(2);
        end

        // R8: stray completions while empty
        cmpl_irq = 1'b1; cmpl_err = 8'hFF; step(3); idle(); step(1);

        // R8 and R3: stray completion on the edge a request lands in an empty queue
        put(6, 'h66, 1'b0, 1'b1); cmpl_irq = 1'b1; step(1); idle(); step(2);

        // R9: last entry retires on the edge a new request is accepted
        put(7, 'h77, 1'b1, 1'b1); cmpl_irq = 1'b1; cmpl_err = 8'h09; step(1); idle(); step(2);
        cmpl_irq = 1'b1; step(1); idle(); step(1);

        // R7: fill beyond depth, then drain
        for (int i = 0; i < DEPTH + 3; i++) begin
            put(i % DQ_NUM_TAGS, 'h1000 + i, i[0], i[1]); step(1);
        end
        idle(); step(2);
        chk(req_ready == 1'b0, "R7", "ready low when full", req_ready, 0);
        for (int i = 0; i < DEPTH + 1; i++) begin
            cmpl_irq = 1'b1; cmpl_err = ERR_W'(8'h80 + i); step(1);
        end
        idle(); step(2);

        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            req_valid = ($urandom % 3) == 0;
            req_tag   = DQ_TAG_W'($urandom);
            req_lba   = DQ_LBA_W'($urandom);
            req_drive = 1'($urandom);
            req_write = 1'($urandom);
            cmpl_irq  = ($urandom % 4) == 0;
            cmpl_err  = ERR_W'($urandom);
            step(1);
        end
        idle(); step(4);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule